// File: doc/BRIEF.md
# Fixed-Point Vertex Transform Unit

This block turns a homogeneous point (x, y, z, w) into screen space. It applies three programmable 4x4 matrices in turn, called stage 0, stage 1 and stage 2, with stage 0 applied first. It then divides x, y and z by the transformed w. All values are signed fixed-point numbers with 16 integer bits and 16 fraction bits. Only four multipliers exist. Each cycle they form one full four-term dot product, so a matrix-vector product takes four cycles. A single iterative divider handles the three divisions one after another.

Matrix elements are loaded one at a time through a write port. That port is open only while no vertex is in flight. A fused mode multiplies the three stage matrices together once, using the same four multipliers. Each vertex then needs a single matrix pass instead of three. After any matrix write, the unit rebuilds the combined matrix before it accepts the next vertex in fused mode. Vertices enter and leave over valid/ready handshakes. One vertex is in flight at a time, so results leave in input order.

Top module: `vxf_top`

## Requirements
- R1: Every dot product adds the four exact 64-bit products, adds 2^15, shifts right arithmetically by 16 and saturates to the 32-bit signed range (0x7FFFFFFF / 0x80000000).
- R2: After reset all three stage matrices are the identity (diagonal 0x00010000), out_valid is 0, cfg_ready is 1 and, with fused_mode low, in_ready is 1.
- R3: With fused_mode low at acceptance, the transformed vector is S2·(S1·(S0·v)), rounded and saturated per R1 after each stage.
- R4: A write sets element (cfg_row, cfg_col) of stage cfg_mat (0..2) to cfg_data when cfg_we and cfg_ready are both high. A write with cfg_mat = 3, or while cfg_ready is low, changes nothing.
- R5: When the transformed w is nonzero, out_x/out_y/out_z equal (coordinate·2^16)/w truncated toward zero and saturated to 32 bits, and out_w equals the transformed w.
- R6: When the transformed w is zero, out_wzero is 1, out_w is 0 and out_x, out_y and out_z are 0. Otherwise out_wzero is 0.
- R7: With fused_mode high at acceptance, the vector is C·v, where P = S1·S0 and C = S2·P are each rounded per element per R1. After reset or any matrix write, in_ready stays low in fused mode until C has been rebuilt.
- R8: An output held with out_ready low keeps every output field stable. While a vertex is in flight or waiting at the output, in_ready is low.
- R9: A configuration write takes priority: in_ready is low in any cycle with cfg_we high.
- R10: cfg_ready is low from vertex acceptance until its output is taken, and during a fused rebuild.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Matrix element write request |
| cfg_mat | input | 2 | Stage matrix index, 0 to 2 |
| cfg_row | input | 2 | Element row |
| cfg_col | input | 2 | Element column |
| cfg_data | input | 32 | Element value, Q16.16 |
| cfg_ready | output | 1 | Matrix writes are taken |
| fused_mode | input | 1 | Use the combined matrix for the next vertex |
| in_valid | input | 1 | Input vertex valid |
| in_ready | output | 1 | Input vertex accepted this cycle if valid |
| in_x | input | 32 | Input x, Q16.16 |
| in_y | input | 32 | Input y, Q16.16 |
| in_z | input | 32 | Input z, Q16.16 |
| in_w | input | 32 | Input w, Q16.16 |
| out_valid | output | 1 | Output vertex valid |
| out_ready | input | 1 | Output vertex taken |
| out_x | output | 32 | Screen x, Q16.16 |
| out_y | output | 32 | Screen y, Q16.16 |
| out_z | output | 32 | Screen z, Q16.16 |
| out_w | output | 32 | Transformed w, Q16.16 |
| out_wzero | output | 1 | Transformed w was zero; no divide done |

## Verification
The bench builds the block at the package defaults: a 32-bit word, 16 fraction bits, 4-element vectors and three stages. At that size a single matrix element of 0x7FFFFFFF drives a dot product into saturation, and a w of one LSB drives the divider past the 32-bit range. A stage that copies z into w makes a zero w easy to reach with an ordinary input. The reference uses 80-bit arithmetic and native integer division, so every rounding, saturation and sign case can be predicted exactly for both the chained and the fused path.

// File: rtl/vxf_pkg.sv
package vxf_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned FRAC_W = 16;
    localparam int unsigned VEC_N  = 4;
    localparam int unsigned MAT_N  = 3;
    localparam int unsigned IDX_W  = $clog2(VEC_N);
    localparam int unsigned SEL_W  = 2;

    typedef logic [DATA_W-1:0] fx_t;
    typedef logic [VEC_N-1:0][DATA_W-1:0] vec_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FUSE_A,
        S_FUSE_B,
        S_XFORM,
        S_DIV_GO,
        S_DIV_WAIT,
        S_OUT
    } vxf_state_e;

    localparam fx_t FX_ONE = fx_t'(1) << FRAC_W;
    localparam fx_t FX_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam fx_t FX_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic fx_t fx_ident(input int unsigned r, input int unsigned c);
        return (r == c) ? FX_ONE : '0;
    endfunction

    function automatic fx_t fx_abs(input fx_t v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction
endpackage

// File: rtl/vxf_dot4.sv
module vxf_dot4
    import vxf_pkg::*;
(
    input  vec_t a,
    input  vec_t b,
    output fx_t  y
);
    localparam int unsigned PROD_W = 2 * DATA_W;
    localparam int unsigned SUM_W  = PROD_W + IDX_W;
    localparam int unsigned HI_W   = SUM_W - DATA_W + 1;

    logic signed [PROD_W-1:0] prod [VEC_N];
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  rnd;
    logic signed [SUM_W-1:0]  shr;
    logic [HI_W-1:0]          hi;

    generate
        for (genvar i = 0; i < VEC_N; i++) begin : g_mul
            assign prod[i] = $signed(a[i]) * $signed(b[i]);
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int i = 0; i < VEC_N; i++) begin
            sum = sum + {{IDX_W{prod[i][PROD_W-1]}}, prod[i]};
        end
        rnd = sum + (SUM_W'(1) << (FRAC_W - 1));
        shr = rnd >>> FRAC_W;
        hi  = shr[SUM_W-1:DATA_W-1];
        if (hi == '0 || hi == '1) begin
            y = shr[DATA_W-1:0];
        end else begin
            y = shr[SUM_W-1] ? FX_MIN : FX_MAX;
        end
    end
endmodule

// File: rtl/vxf_div.sv
module vxf_div
    import vxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  fx_t  num,
    input  fx_t  den,
    output logic busy,
    output logic done,
    output fx_t  quo
);
    localparam int unsigned Q_W   = DATA_W + FRAC_W;
    localparam int unsigned CNT_W = $clog2(Q_W);
    localparam logic [Q_W-1:0] LIM = Q_W'(1) << (DATA_W - 1);

    logic [Q_W-1:0]   shq;
    logic [DATA_W:0]  rem;
    logic [DATA_W:0]  trial;
    fx_t              dmag;
    logic             neg;
    logic [CNT_W-1:0] cnt;

    assign trial = {rem[DATA_W-1:0], shq[Q_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shq  <= '0;
            rem  <= '0;
            dmag <= '0;
            neg  <= 1'b0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                neg  <= num[DATA_W-1] ^ den[DATA_W-1];
                shq  <= {fx_abs(num), {FRAC_W{1'b0}}};
                dmag <= fx_abs(den);
                rem  <= '0;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, dmag}) begin
                    rem <= trial - {1'b0, dmag};
                    shq <= {shq[Q_W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    shq <= {shq[Q_W-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(Q_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (!neg) begin
            quo = (shq >= LIM) ? FX_MAX : shq[DATA_W-1:0];
        end else begin
            quo = (shq > LIM) ? FX_MIN : (~shq[DATA_W-1:0] + 1'b1);
        end
    end

    p_div_free_r5: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    p_div_den_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> den != '0);
    p_div_end_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !$past(done));
endmodule

// File: rtl/vxf_mat_bank.sv
module vxf_mat_bank
    import vxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [IDX_W-1:0] wrow,
    input  logic [IDX_W-1:0] wcol,
    input  fx_t              wdata,
    input  logic [SEL_W-1:0] rsel_row,
    input  logic [IDX_W-1:0] rrow,
    output vec_t             row_o,
    input  logic [SEL_W-1:0] rsel_col,
    input  logic [IDX_W-1:0] rcol,
    output vec_t             col_o
);
    fx_t mem [MAT_N][VEC_N][VEC_N];

    generate
        for (genvar k = 0; k < MAT_N; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int r = 0; r < VEC_N; r++) begin
                        for (int c = 0; c < VEC_N; c++) begin
                            mem[k][r][c] <= fx_ident(r, c);
                        end
                    end
                end else if (we && wsel == SEL_W'(k)) begin
                    mem[k][wrow][wcol] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        row_o = '0;
        col_o = '0;
        for (int k = 0; k < MAT_N; k++) begin
            for (int i = 0; i < VEC_N; i++) begin
                if (rsel_row == SEL_W'(k)) row_o[i] = mem[k][rrow][i];
                if (rsel_col == SEL_W'(k)) col_o[i] = mem[k][i][rcol];
            end
        end
    end
endmodule

// File: rtl/vxf_top.sv
module vxf_top
    import vxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_mat,
    input  logic [1:0]  cfg_row,
    input  logic [1:0]  cfg_col,
    input  logic [31:0] cfg_data,
    output logic        cfg_ready,
    input  logic        fused_mode,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_x,
    input  logic [31:0] in_y,
    input  logic [31:0] in_z,
    input  logic [31:0] in_w,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_x,
    output logic [31:0] out_y,
    output logic [31:0] out_z,
    output logic [31:0] out_w,
    output logic        out_wzero
);
    localparam int unsigned CNT_W = 2 * IDX_W;
    localparam logic [SEL_W-1:0] LAST_STAGE = SEL_W'(MAT_N - 1);
    localparam int unsigned WI = VEC_N - 1;

    vxf_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] stage;
    logic [IDX_W-1:0] dsub;
    logic             dirty;
    logic             mode_q;
    logic             wz;
    vec_t             v, tmp, res;
    fx_t              pmat [VEC_N][VEC_N];
    fx_t              cmat [VEC_N][VEC_N];

    logic [IDX_W-1:0] er, ec, xrow;
    logic [SEL_W-1:0] rsel_row;
    logic [IDX_W-1:0] rrow;
    vec_t             bank_row, bank_col, pcol, crow, op_a, op_b;
    fx_t              dot_y;
    logic             div_start, div_busy, div_done;
    fx_t              div_q;
    logic             cfg_take;

    assign er        = cnt[CNT_W-1:IDX_W];
    assign ec        = cnt[IDX_W-1:0];
    assign xrow      = cnt[IDX_W-1:0];
    assign cfg_ready = (st == S_IDLE);
    assign cfg_take  = cfg_we && cfg_ready;
    assign in_ready  = (st == S_IDLE) && !cfg_we && !(fused_mode && dirty);
    assign out_valid = (st == S_OUT);
    assign div_start = (st == S_DIV_GO);
    assign out_x     = res[0];
    assign out_y     = res[1];
    assign out_z     = res[2];
    assign out_w     = v[WI];
    assign out_wzero = wz;

    always_comb begin
        case (st)
            S_FUSE_A: rsel_row = SEL_W'(1);
            S_FUSE_B: rsel_row = SEL_W'(2);
            default:  rsel_row = stage;
        endcase
        rrow = (st == S_XFORM) ? xrow : er;
        for (int j = 0; j < VEC_N; j++) begin
            pcol[j] = pmat[j][ec];
            crow[j] = cmat[xrow][j];
        end
        case (st)
            S_FUSE_A: begin op_a = bank_row; op_b = bank_col; end
            S_FUSE_B: begin op_a = bank_row; op_b = pcol;     end
            default:  begin op_a = mode_q ? crow : bank_row; op_b = v; end
        endcase
    end

    vxf_mat_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_take),
        .wsel     (cfg_mat),
        .wrow     (cfg_row),
        .wcol     (cfg_col),
        .wdata    (cfg_data),
        .rsel_row (rsel_row),
        .rrow     (rrow),
        .row_o    (bank_row),
        .rsel_col (SEL_W'(0)),
        .rcol     (ec),
        .col_o    (bank_col)
    );

    vxf_dot4 u_dot (
        .a (op_a),
        .b (op_b),
        .y (dot_y)
    );

    vxf_div u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (v[dsub]),
        .den   (v[WI]),
        .busy  (div_busy),
        .done  (div_done),
        .quo   (div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            stage  <= '0;
            dsub   <= '0;
            dirty  <= 1'b1;
            mode_q <= 1'b0;
            wz     <= 1'b0;
            v      <= '0;
            tmp    <= '0;
            res    <= '0;
            for (int r = 0; r < VEC_N; r++) begin
                for (int c = 0; c < VEC_N; c++) begin
                    pmat[r][c] <= '0;
                    cmat[r][c] <= '0;
                end
            end
        end else begin
            if (cfg_take && cfg_mat < SEL_W'(MAT_N)) dirty <= 1'b1;
            case (st)
                S_IDLE: begin
                    if (in_valid && in_ready) begin
                        v      <= {in_w, in_z, in_y, in_x};
                        mode_q <= fused_mode;
                        stage  <= '0;
                        cnt    <= '0;
                        st     <= S_XFORM;
                    end else if (fused_mode && dirty && !cfg_we) begin
                        cnt <= '0;
                        st  <= S_FUSE_A;
                    end
                end
                S_FUSE_A: begin
                    pmat[er][ec] <= dot_y;
                    cnt <= cnt + 1'b1;
                    if (cnt == '1) st <= S_FUSE_B;
                end
                S_FUSE_B: begin
                    cmat[er][ec] <= dot_y;
                    cnt <= cnt + 1'b1;
                    if (cnt == '1) begin
                        dirty <= 1'b0;
                        st    <= S_IDLE;
                    end
                end
                S_XFORM: begin
                    tmp[xrow] <= dot_y;
                    if (xrow == IDX_W'(WI)) begin
                        for (int j = 0; j < WI; j++) v[j] <= tmp[j];
                        v[WI] <= dot_y;
                        cnt   <= '0;
                        if (mode_q || stage == LAST_STAGE) begin
                            dsub <= '0;
                            if (dot_y == '0) begin
                                res <= '0;
                                wz  <= 1'b1;
                                st  <= S_OUT;
                            end else begin
                                wz <= 1'b0;
                                st <= S_DIV_GO;
                            end
                        end else begin
                            stage <= stage + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DIV_GO: st <= S_DIV_WAIT;
                S_DIV_WAIT: begin
                    if (div_done) begin
                        res[dsub] <= div_q;
                        if (dsub == IDX_W'(WI - 1)) begin
                            st <= S_OUT;
                        end else begin
                            dsub <= dsub + 1'b1;
                            st   <= S_DIV_GO;
                        end
                    end
                end
                S_OUT: if (out_ready) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
            && $stable(out_z) && $stable(out_w) && $stable(out_wzero));
    p_one_inflight_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready && !out_valid && !cfg_ready);
    p_wzero_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_wzero |-> out_w == '0 && out_x == '0 && out_y == '0 && out_z == '0);
    p_wlive_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_wzero |-> out_w != '0);
    p_cfg_shut_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !cfg_ready && !in_ready);
endmodule

// File: tb/sim_vxf_top.sv
module sim_vxf_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mat = '0, cfg_row = '0, cfg_col = '0;
    logic [31:0] cfg_data = '0;
    logic        cfg_ready;
    logic        fused_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_x = '0, in_y = '0, in_z = '0, in_w = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_x, out_y, out_z, out_w;
    logic        out_wzero;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    int bm [3][4][4];
    localparam int ONE = 65536;

    always #10 clk = ~clk;

    vxf_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mat(cfg_mat), .cfg_row(cfg_row),
        .cfg_col(cfg_col), .cfg_data(cfg_data), .cfg_ready(cfg_ready),
        .fused_mode(fused_mode), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_w(in_w), .out_valid(out_valid),
        .out_ready(out_ready), .out_x(out_x), .out_y(out_y), .out_z(out_z),
        .out_w(out_w), .out_wzero(out_wzero)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bdot(input int a[4], input int b[4]);
        logic signed [79:0] s, p;
        s = '0;
        for (int i = 0; i < 4; i++) begin
            p = longint'(a[i]) * longint'(b[i]);
            s = s + p;
        end
        s = (s + 80'sd32768) >>> 16;
        if (s > 80'sd2147483647) return 32'h7FFFFFFF;
        if (s < -80'sd2147483648) return 32'h80000000;
        return int'(s);
    endfunction

    function automatic int bdiv(input int n, input int d);
        longint q;
        q = (longint'(n) * 65536) / longint'(d);
        if (q > 64'sd2147483647) return 32'h7FFFFFFF;
        if (q < -64'sd2147483648) return 32'h80000000;
        return int'(q);
    endfunction

    function automatic void apply(input int m [4][4], inout int v[4]);
        int r[4];
        int row[4];
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) row[j] = m[i][j];
            r[i] = bdot(row, v);
        end
        v = r;
    endfunction

    task automatic model(input int vin[4], input bit fused, output int ex[4], output bit ewz);
        int v[4];
        int p[4][4];
        int c[4][4];
        int ra[4];
        int cb[4];
        v = vin;
        if (fused) begin
            for (int r = 0; r < 4; r++)
                for (int k = 0; k < 4; k++) begin
                    for (int j = 0; j < 4; j++) begin ra[j] = bm[1][r][j]; cb[j] = bm[0][j][k]; end
                    p[r][k] = bdot(ra, cb);
                end
            for (int r = 0; r < 4; r++)
                for (int k = 0; k < 4; k++) begin
                    for (int j = 0; j < 4; j++) begin ra[j] = bm[2][r][j]; cb[j] = p[j][k]; end
                    c[r][k] = bdot(ra, cb);
                end
            apply(c, v);
        end else begin
            for (int s = 0; s < 3; s++) apply(bm[s], v);
        end
        ewz = (v[3] == 0);
        for (int i = 0; i < 3; i++) ex[i] = ewz ? 0 : bdiv(v[i], v[3]);
        ex[3] = v[3];
    endtask

    task automatic wr(input int m, input int r, input int c, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mat = 2'(m); cfg_row = 2'(r); cfg_col = 2'(c); cfg_data = d;
        #1;
        while (!cfg_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (m < 3) bm[m][r][c] = d;
    endtask

    task automatic ident_all();
        for (int m = 0; m < 3; m++)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    wr(m, r, c, (r == c) ? ONE : 0);
    endtask

    task automatic send(input int x, input int y, input int z, input int w);
        @(negedge clk);
        in_x = x; in_y = y; in_z = z; in_w = w; in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_out();
        @(negedge clk); #1;
        while (!out_valid) begin @(negedge clk); #1; end
    endtask

    task automatic take_check(input string req, input int vin[4]);
        int ex[4];
        bit ewz;
        model(vin, fused_mode, ex, ewz);
        chk(req, "out_x", longint'($signed(out_x)), longint'(ex[0]));
        chk(req, "out_y", longint'($signed(out_y)), longint'(ex[1]));
        chk(req, "out_z", longint'($signed(out_z)), longint'(ex[2]));
        chk(req, "out_w", longint'($signed(out_w)), longint'(ex[3]));
        chk(req, "out_wzero", longint'(out_wzero), longint'(ewz));
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    task automatic run(input string req, input int x, input int y, input int z, input int w);
        int vin[4];
        vin = '{x, y, z, w};
        send(x, y, z, w);
        wait_out();
        take_check(req, vin);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int vin[4];
        int xs;
        for (int m = 0; m < 3; m++)
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++)
                    bm[m][r][c] = (r == c) ? ONE : 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R2 reset state
        chk("R2", "out_valid", longint'(out_valid), 0);
        chk("R2", "cfg_ready", longint'(cfg_ready), 1);
        chk("R2", "in_ready", longint'(in_ready), 1);

        // R2/R5 identity matrices: (2,4,6,2) -> (1,2,3,2)
        send(2*ONE, 4*ONE, 6*ONE, 2*ONE);
        wait_out();
        chk("R5", "identity x", longint'($signed(out_x)), 1*ONE);
        chk("R5", "identity z", longint'($signed(out_z)), 3*ONE);
        vin = '{2*ONE, 4*ONE, 6*ONE, 2*ONE};
        take_check("R2", vin);

        // R3/R4 chained stages with fractional and negative entries
        wr(0, 0, 0, 2*ONE); wr(0, 1, 1, 2*ONE); wr(0, 0, 3, ONE + ONE/2);
        wr(1, 1, 0, -16384); wr(1, 2, 2, 19661); wr(1, 0, 1, -3);
        wr(2, 3, 2, ONE); wr(2, 3, 3, 0);
        run("R3", ONE, -2*ONE, 3*ONE, ONE);
        run("R1", 12345, -777, 98765, ONE);

        // R6 zero w (stage 2 copies z into w)
        run("R6", 5*ONE, 7*ONE, 0, ONE);
        // R5 negative w
        run("R5", 3*ONE, ONE, -2*ONE, ONE);

        // R10/R4 writes while busy are ignored
        send(ONE, ONE, 2*ONE, ONE);
        @(negedge clk); #1;
        chk("R10", "cfg_ready busy", longint'(cfg_ready), 0);
        cfg_we = 1'b1; cfg_mat = 2'd1; cfg_row = 2'd2; cfg_col = 2'd2; cfg_data = 32'h00500000;
        repeat (3) @(negedge clk);
        #1 cfg_we = 1'b0;
        wait_out();
        vin = '{ONE, ONE, 2*ONE, ONE};
        take_check("R10", vin);
        run("R4", 2*ONE, ONE, 2*ONE, ONE);
        // R4 index 3 ignored
        wr(3, 2, 2, 32'h00700000);
        run("R4", 2*ONE, ONE, 2*ONE, ONE);

        // R9 configuration write blocks input acceptance
        @(negedge clk);
        cfg_we = 1'b1; cfg_mat = 2'd0; cfg_row = 2'd0; cfg_col = 2'd0; cfg_data = bm[0][0][0];
        in_valid = 1'b1; in_x = ONE; in_y = ONE; in_z = ONE; in_w = ONE;
        #1;
        chk("R9", "in_ready during write", longint'(in_ready), 0);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b0;
        wait_out();
        vin = '{ONE, ONE, ONE, ONE};
        take_check("R9", vin);

        // R8 backpressure holds output
        send(4*ONE, -ONE, 2*ONE, ONE);
        wait_out();
        xs = out_x;
        repeat (5) @(negedge clk);
        #1;
        chk("R8", "out_valid held", longint'(out_valid), 1);
        chk("R8", "out_x stable", longint'(out_x), longint'(xs));
        chk("R8", "in_ready held", longint'(in_ready), 0);
        chk("R10", "cfg_ready held", longint'(cfg_ready), 0);
        vin = '{4*ONE, -ONE, 2*ONE, ONE};
        take_check("R8", vin);

        // R1 saturation in a dot product, R5 divide saturation
        ident_all();
        wr(0, 0, 0, 32'h7FFFFFFF);
        run("R1", 100*ONE, ONE, ONE, ONE);
        wr(0, 0, 0, ONE);
        send(ONE, -ONE, 0, 1);
        wait_out();
        chk("R5", "div sat pos", longint'(out_x), 64'h7FFFFFFF);
        chk("R5", "div sat neg", longint'(out_y), 64'h80000000);
        vin = '{ONE, -ONE, 0, 1};
        take_check("R5", vin);

        // R7 fused mode
        wr(0, 0, 0, 2*ONE); wr(0, 0, 3, ONE + ONE/2); wr(1, 1, 0, -16384);
        wr(1, 2, 2, 19661); wr(2, 3, 2, ONE); wr(2, 3, 3, 0); wr(2, 0, 1, 21845);
        @(negedge clk);
        fused_mode = 1'b1;
        #1;
        chk("R7", "in_ready stale", longint'(in_ready), 0);
        run("R7", ONE, -2*ONE, 3*ONE, ONE);
        run("R7", 7*ONE, 3, -5*ONE, 2*ONE);
        wr(1, 1, 1, 3*ONE);
        run("R7", ONE, 2*ONE, 3*ONE, ONE);
        run("R6", ONE, ONE, 0, ONE);
        fused_mode = 1'b0;
        run("R3", ONE, 2*ONE, 3*ONE, ONE);

        finish_run();
    end
endmodule